// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, which pipeline registers of a five-stage in-order processor (fetch, decode, execute, memory, writeback) must hold their contents and which must be loaded with a no-operation bubble. It is purely combinational. It looks at the instruction codes in the decode, execute and memory stages, at the two source register IDs of the decode stage, at the load destination in execute, and at the branch condition that execute has just resolved.

Three conditions are recognised. The first is a load whose result the next instruction reads, which causes a one-cycle interlock. The second is a return in flight, which drains the pipe until the return address is known. The third is a conditional jump that was predicted taken but resolved not taken, which squashes the two wrong-path instructions. When several conditions are present in the same cycle, a fixed priority resolves them. Operand forwarding and the datapath live elsewhere and only consume the controls.

Top module: `hazard_ctrl`

## Requirements
- R1: A load/use interlock exists when the execute instruction code is a memory load (0x5) or a stack pop (0x0B), its destination ID is not 0xF, and that ID equals the decode source A or source B. It then stalls fetch and decode and bubbles execute, for that cycle only. A non-load instruction in execute with the same destination causes nothing.
- R2: Register ID 0xF means "no register" and never produces an interlock, even when every source and destination field equals 0xF.
- R3: A return (code 0x9) in decode, execute or memory, with no interlock and no mispredict, stalls fetch and bubbles decode. It stalls nothing else and bubbles nothing else.
- R4: A conditional jump (code 0x7) in execute whose condition input is 0 bubbles decode and execute and stalls no register.
- R5: A conditional jump in execute whose condition input is 1 produces no control.
- R6: A mispredict takes precedence over a return. When both are present, fetch is not stalled, and decode and execute are bubbled.
- R7: When an interlock and a return coincide, decode is stalled rather than bubbled, fetch is stalled and execute is bubbled.
- R8: The memory and writeback registers are never stalled or bubbled.
- R9: No register ever receives a stall and a bubble at the same time.
- R10: With no interlock, no return and no mispredict, every stall and every bubble output is 0.

Bit order of both control vectors: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode_i | input | 4 | Instruction code in decode |
| d_src_a_i | input | 4 | Decode source register A (0xF = none) |
| d_src_b_i | input | 4 | Decode source register B (0xF = none) |
| e_icode_i | input | 4 | Instruction code in execute |
| e_dst_m_i | input | 4 | Memory-result destination register in execute |
| e_cond_i | input | 1 | Resolved jump condition in execute (1 = taken) |
| m_icode_i | input | 4 | Instruction code in memory |
| stall_o | output | 5 | Hold request per pipeline register |
| bubble_o | output | 5 | Bubble request per pipeline register |

## Verification
A table of hand-computed cases covers each condition alone: a load matching on source A, a pop matching on source B, a non-matching load, a non-load with a matching destination field, and a return at each of its three stage positions. This separates a wrong match on the operands from a wrong opcode decode. Paired cases put a mispredict against a return and an interlock against a return, so that a wrong priority order shows up as a different control vector. A sweep over every execute code, both condition values, a return present or absent in decode and memory, and a matching or non-matching destination then compares the outputs with a model built from the requirements. The same sweep checks that stall and bubble never coincide on any register and that the last two registers stay quiet.

// File: rtl/hc_pkg.sv
package hc_pkg;

   // Pipeline register positions inside the stall and bubble vectors.
   typedef enum int unsigned {
      ST_F = 0,
      ST_D = 1,
      ST_E = 2,
      ST_M = 3,
      ST_W = 4
   } stage_e;

   localparam int unsigned NSTAGE = 5;

   // Raw hazard conditions before priority resolution.
   typedef struct packed {
      logic load_use;
      logic ret_busy;
      logic mispred;
   } hz_flags_t;

endpackage

// File: rtl/hc_load_use.sv
module hc_load_use #(
   parameter int unsigned REG_W         = 4,
   parameter int unsigned ICODE_W       = 4,
   parameter logic [REG_W-1:0]   REG_NONE = '1,
   parameter logic [ICODE_W-1:0] IC_LOAD  = 4'h5,
   parameter logic [ICODE_W-1:0] IC_POP   = 4'hB,
   parameter bit                 POP_READS_MEM = 1'b1
) (
   input  logic [ICODE_W-1:0] e_icode_i,
   input  logic [REG_W-1:0]   e_dst_m_i,
   input  logic [REG_W-1:0]   d_src_a_i,
   input  logic [REG_W-1:0]   d_src_b_i,
   output logic               hit_o
);

   logic is_load;
   logic dst_real;
   logic src_match;

   // The set of opcodes that read memory into a register is a build option.
   generate
      if (POP_READS_MEM) begin : g_load_and_pop
         assign is_load = (e_icode_i == IC_LOAD) || (e_icode_i == IC_POP);
      end else begin : g_load_only
         assign is_load = (e_icode_i == IC_LOAD);
      end
   endgenerate

   // A missing destination can never match, so a missing source never
   // produces an interlock either.
   assign dst_real  = (e_dst_m_i != REG_NONE);
   assign src_match = (e_dst_m_i == d_src_a_i) || (e_dst_m_i == d_src_b_i);
   assign hit_o     = is_load && dst_real && src_match;

endmodule

// File: rtl/hc_ret_scan.sv
module hc_ret_scan #(
   parameter int unsigned ICODE_W = 4,
   parameter int unsigned NWATCH  = 3,
   parameter logic [ICODE_W-1:0] IC_RET = 4'h9
) (
   input  logic [NWATCH*ICODE_W-1:0] icodes_i,
   output logic                      busy_o
);

   logic [NWATCH-1:0] slot_hit;

   // One comparator per watched stage.
   generate
      for (genvar g = 0; g < NWATCH; g++) begin : g_slot
         assign slot_hit[g] = (icodes_i[g*ICODE_W +: ICODE_W] == IC_RET);
      end
   endgenerate

   assign busy_o = |slot_hit;

endmodule

// File: rtl/hc_mispredict.sv
module hc_mispredict #(
   parameter int unsigned ICODE_W = 4,
   parameter logic [ICODE_W-1:0] IC_JXX = 4'h7
) (
   input  logic [ICODE_W-1:0] e_icode_i,
   input  logic               e_cond_i,
   output logic               mis_o
);

   // Jumps are predicted taken, so a false condition is a mispredict.
   assign mis_o = (e_icode_i == IC_JXX) && !e_cond_i;

endmodule

// File: rtl/hc_resolve.sv
module hc_resolve
   import hc_pkg::*;
#(
   parameter int unsigned NST = NSTAGE
) (
   input  hz_flags_t          flags_i,
   output logic [NST-1:0]     stall_o,
   output logic [NST-1:0]     bubble_o
);

   // Priority: mispredict, then interlock, then return drain.
   always_comb begin
      stall_o  = '0;
      bubble_o = '0;
      if (flags_i.mispred) begin
         bubble_o[ST_D] = 1'b1;
         bubble_o[ST_E] = 1'b1;
      end else if (flags_i.load_use) begin
         stall_o[ST_F]  = 1'b1;
         stall_o[ST_D]  = 1'b1;
         bubble_o[ST_E] = 1'b1;
      end else if (flags_i.ret_busy) begin
         stall_o[ST_F]  = 1'b1;
         bubble_o[ST_D] = 1'b1;
      end
   end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hc_pkg::*;
#(
   parameter int unsigned REG_W   = 4,
   parameter int unsigned ICODE_W = 4,
   parameter logic [REG_W-1:0]   REG_NONE = '1,
   parameter logic [ICODE_W-1:0] IC_LOAD  = 4'h5,
   parameter logic [ICODE_W-1:0] IC_POP   = 4'hB,
   parameter logic [ICODE_W-1:0] IC_RET   = 4'h9,
   parameter logic [ICODE_W-1:0] IC_JXX   = 4'h7,
   parameter bit                 POP_READS_MEM = 1'b1
) (
   input  logic [ICODE_W-1:0] d_icode_i,
   input  logic [REG_W-1:0]   d_src_a_i,
   input  logic [REG_W-1:0]   d_src_b_i,
   input  logic [ICODE_W-1:0] e_icode_i,
   input  logic [REG_W-1:0]   e_dst_m_i,
   input  logic               e_cond_i,
   input  logic [ICODE_W-1:0] m_icode_i,
   output logic [4:0]         stall_o,
   output logic [4:0]         bubble_o
);

   localparam int unsigned NWATCH = 3;

   // Elaboration-time parameter checks.
   generate
      if (REG_W < 1) begin : g_bad_reg_w
         $error("REG_W must be at least 1");
      end
      if (ICODE_W < 2) begin : g_bad_icode_w
         $error("ICODE_W must be at least 2");
      end
      if (IC_RET == IC_JXX || IC_RET == IC_LOAD || IC_JXX == IC_LOAD) begin : g_bad_codes
         $error("opcode parameters must be distinct");
      end
      if (NSTAGE != 5) begin : g_bad_stages
         $error("control vectors assume five pipeline registers");
      end
   endgenerate

   hz_flags_t flags;
   logic      lu_hit;
   logic      ret_busy;
   logic      mis;

   hc_load_use #(
      .REG_W         (REG_W),
      .ICODE_W       (ICODE_W),
      .REG_NONE      (REG_NONE),
      .IC_LOAD       (IC_LOAD),
      .IC_POP        (IC_POP),
      .POP_READS_MEM (POP_READS_MEM)
   ) u_load_use (
      .e_icode_i (e_icode_i),
      .e_dst_m_i (e_dst_m_i),
      .d_src_a_i (d_src_a_i),
      .d_src_b_i (d_src_b_i),
      .hit_o     (lu_hit)
   );

   hc_ret_scan #(
      .ICODE_W (ICODE_W),
      .NWATCH  (NWATCH),
      .IC_RET  (IC_RET)
   ) u_ret_scan (
      .icodes_i ({m_icode_i, e_icode_i, d_icode_i}),
      .busy_o   (ret_busy)
   );

   hc_mispredict #(
      .ICODE_W (ICODE_W),
      .IC_JXX  (IC_JXX)
   ) u_mispredict (
      .e_icode_i (e_icode_i),
      .e_cond_i  (e_cond_i),
      .mis_o     (mis)
   );

   assign flags.load_use = lu_hit;
   assign flags.ret_busy = ret_busy;
   assign flags.mispred  = mis;

   hc_resolve #(
      .NST (NSTAGE)
   ) u_resolve (
      .flags_i  (flags),
      .stall_o  (stall_o),
      .bubble_o (bubble_o)
   );

endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
   parameter int unsigned REG_W   = 4,
   parameter int unsigned ICODE_W = 4,
   parameter logic [REG_W-1:0]   REG_NONE = '1,
   parameter logic [ICODE_W-1:0] IC_LOAD  = 4'h5,
   parameter logic [ICODE_W-1:0] IC_POP   = 4'hB,
   parameter logic [ICODE_W-1:0] IC_RET   = 4'h9,
   parameter logic [ICODE_W-1:0] IC_JXX   = 4'h7
) (
   input logic [ICODE_W-1:0] d_icode_i,
   input logic [REG_W-1:0]   d_src_a_i,
   input logic [REG_W-1:0]   d_src_b_i,
   input logic [ICODE_W-1:0] e_icode_i,
   input logic [REG_W-1:0]   e_dst_m_i,
   input logic               e_cond_i,
   input logic [ICODE_W-1:0] m_icode_i,
   input logic [4:0]         stall_o,
   input logic [4:0]         bubble_o
);

   logic c_ret;
   logic c_mis;
   logic c_ldfam;

   assign c_ret   = (d_icode_i == IC_RET) || (e_icode_i == IC_RET) || (m_icode_i == IC_RET);
   assign c_mis   = (e_icode_i == IC_JXX) && !e_cond_i;
   assign c_ldfam = (e_icode_i == IC_LOAD) || (e_icode_i == IC_POP);

   always_comb begin
      p_excl_r9: assert ((stall_o & bubble_o) == 5'b0)
         else $error("stall and bubble together");
      p_tail_quiet_r8: assert (stall_o[4:3] == 2'b0 && bubble_o[4:3] == 2'b0)
         else $error("memory or writeback controlled");
      if (c_mis) begin
         p_squash_r4: assert (bubble_o[2:1] == 2'b11 && stall_o == 5'b0)
            else $error("mispredict not squashed");
      end
      if (c_ldfam && e_dst_m_i != REG_NONE && !c_mis &&
          (e_dst_m_i == d_src_a_i || e_dst_m_i == d_src_b_i)) begin
         p_interlock_r1: assert (stall_o[1:0] == 2'b11 && bubble_o[2:0] == 3'b100)
            else $error("interlock wrong");
      end
      if (e_dst_m_i == REG_NONE && !c_ret && !c_mis) begin
         p_none_quiet_r2: assert (stall_o == 5'b0 && bubble_o == 5'b0)
            else $error("no-register id caused a control");
      end
      if (c_ret && !c_mis && stall_o[1] == 1'b0) begin
         p_ret_drain_r3: assert (stall_o == 5'b00001 && bubble_o == 5'b00010)
            else $error("return drain wrong");
      end
   end

endmodule

bind hazard_ctrl hc_checker #(
   .REG_W    (REG_W),
   .ICODE_W  (ICODE_W),
   .REG_NONE (REG_NONE),
   .IC_LOAD  (IC_LOAD),
   .IC_POP   (IC_POP),
   .IC_RET   (IC_RET),
   .IC_JXX   (IC_JXX)
) u_hc_checker (
   .d_icode_i (d_icode_i),
   .d_src_a_i (d_src_a_i),
   .d_src_b_i (d_src_b_i),
   .e_icode_i (e_icode_i),
   .e_dst_m_i (e_dst_m_i),
   .e_cond_i  (e_cond_i),
   .m_icode_i (m_icode_i),
   .stall_o   (stall_o),
   .bubble_o  (bubble_o)
);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   // {d_ic, srcA, srcB, e_ic, dstM, cond, m_ic, stall, bubble, req}
   localparam logic [38:0] VEC [NVEC] = '{
      {4'h1,4'hF,4'hF,4'h1,4'hF,1'b0,4'h1,5'b00000,5'b00000,4'd10}, // R10 idle
      {4'h6,4'h3,4'hF,4'h5,4'h3,1'b0,4'h1,5'b00011,5'b00100,4'd1},  // R1 load, srcA
      {4'h6,4'hF,4'h2,4'hB,4'h2,1'b0,4'h1,5'b00011,5'b00100,4'd1},  // R1 pop, srcB
      {4'h6,4'h1,4'h2,4'h5,4'h3,1'b0,4'h1,5'b00000,5'b00000,4'd1},  // R1 no match
      {4'h6,4'h3,4'hF,4'h6,4'h3,1'b0,4'h1,5'b00000,5'b00000,4'd1},  // R1 not a load
      {4'h6,4'hF,4'hF,4'h5,4'hF,1'b0,4'h1,5'b00000,5'b00000,4'd2},  // R2 all none
      {4'h9,4'hF,4'hF,4'h1,4'hF,1'b0,4'h1,5'b00001,5'b00010,4'd3},  // R3 ret in D
      {4'h1,4'hF,4'hF,4'h9,4'hF,1'b0,4'h1,5'b00001,5'b00010,4'd3},  // R3 ret in E
      {4'h1,4'hF,4'hF,4'h1,4'hF,1'b0,4'h9,5'b00001,5'b00010,4'd3},  // R3 ret in M
      {4'h1,4'hF,4'hF,4'h7,4'hF,1'b0,4'h1,5'b00000,5'b00110,4'd4},  // R4 mispredict
      {4'h1,4'hF,4'hF,4'h7,4'hF,1'b1,4'h1,5'b00000,5'b00000,4'd5},  // R5 taken
      {4'h9,4'hF,4'hF,4'h7,4'hF,1'b0,4'h1,5'b00000,5'b00110,4'd6},  // R6 ret in D
      {4'h1,4'hF,4'hF,4'h7,4'hF,1'b0,4'h9,5'b00000,5'b00110,4'd6},  // R6 ret in M
      {4'h6,4'h4,4'hF,4'h5,4'h4,1'b0,4'h9,5'b00011,5'b00100,4'd7},  // R7 ret in M
      {4'h9,4'h4,4'hF,4'h5,4'h4,1'b0,4'h1,5'b00011,5'b00100,4'd7}   // R7 ret in D
   };

   logic       clk = 1'b0;
   logic [3:0] d_icode, d_src_a, d_src_b, e_icode, e_dst_m, m_icode;
   logic       e_cond;
   logic [4:0] stall, bubble;
   int         n_checks = 0;
   int         n_errors = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hazard_ctrl i_hazard_ctrl (
      .d_icode_i (d_icode),
      .d_src_a_i (d_src_a),
      .d_src_b_i (d_src_b),
      .e_icode_i (e_icode),
      .e_dst_m_i (e_dst_m),
      .e_cond_i  (e_cond),
      .m_icode_i (m_icode),
      .stall_o   (stall),
      .bubble_o  (bubble)
   );

   task automatic check(input int req, input string what,
                        input logic [4:0] act, input logic [4:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] dic, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] eic, input logic [3:0] dst, input logic c,
                        input logic [3:0] mic);
      @(negedge clk);
      d_icode = dic; d_src_a = a; d_src_b = b;
      e_icode = eic; e_dst_m = dst; e_cond = c; m_icode = mic;
      #1;
   endtask

   // Model of the requirements: returns {stall, bubble}.
   function automatic logic [9:0] model(input logic [3:0] dic, input logic [3:0] a,
                                        input logic [3:0] b, input logic [3:0] eic,
                                        input logic [3:0] dst, input logic c,
                                        input logic [3:0] mic);
      logic lu, rt, mp;
      lu = (eic == 4'h5 || eic == 4'hB) && dst != 4'hF && (dst == a || dst == b);
      rt = (dic == 4'h9) || (eic == 4'h9) || (mic == 4'h9);
      mp = (eic == 4'h7) && !c;
      if (mp)      return {5'b00000, 5'b00110}; // R4, R6
      else if (lu) return {5'b00011, 5'b00100}; // R1, R7
      else if (rt) return {5'b00001, 5'b00010}; // R3
      else         return {5'b00000, 5'b00000}; // R10
   endfunction

   initial begin
      logic [9:0] ex;
      // Idle state before any hazard is applied.
      drive(4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 1'b0, 4'h1);
      check(10, "idle stall", stall, 5'b0);
      check(10, "idle bubble", bubble, 5'b0);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][38:35], VEC[i][34:31], VEC[i][30:27], VEC[i][26:23],
               VEC[i][22:19], VEC[i][18], VEC[i][17:14]);
         check(int'(VEC[i][3:0]), $sformatf("vector %0d stall", i), stall, VEC[i][13:9]);
         check(int'(VEC[i][3:0]), $sformatf("vector %0d bubble", i), bubble, VEC[i][8:4]);
      end

      // Interlock lasts one cycle: once the load moves on, controls clear (R1).
      drive(4'h6, 4'h3, 4'hF, 4'h5, 4'h3, 1'b0, 4'h1);
      drive(4'h6, 4'h3, 4'hF, 4'h1, 4'hF, 1'b0, 4'h5);
      check(1, "after interlock stall", stall, 5'b0);
      check(1, "after interlock bubble", bubble, 5'b0);

      // No-register id on every field with each load opcode (R2).
      drive(4'h6, 4'hF, 4'hF, 4'hB, 4'hF, 1'b1, 4'h1);
      check(2, "pop to none stall", stall, 5'b0);

      // Sweep of execute code, condition, return placement and match.
      for (int eic = 0; eic < 16; eic++) begin
         for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
               for (int mt = 0; mt < 2; mt++) begin
                  logic [3:0] dic, mic, dst;
                  dic = r[0] ? 4'h9 : 4'h6;
                  mic = r[1] ? 4'h9 : 4'h1;
                  dst = mt[0] ? 4'h2 : 4'hE;
                  drive(dic, 4'h2, 4'h3, 4'(eic), dst, c[0], mic);
                  ex = model(dic, 4'h2, 4'h3, 4'(eic), dst, c[0], mic);
                  check(1, $sformatf("sweep e=%0h c=%0d r=%0d m=%0d stall (R3 R4 R6 R7)",
                        eic, c, r, mt), stall, ex[9:5]);
                  check(1, $sformatf("sweep e=%0h c=%0d r=%0d m=%0d bubble (R3 R4 R6 R7)",
                        eic, c, r, mt), bubble, ex[4:0]);
                  check(9, "R9 stall and bubble exclusive", stall & bubble, 5'b0);
                  check(8, "R8 memory/writeback quiet", {stall[4:3], bubble[4:3]}, 5'b0);
               end
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL R10 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule